// File: doc/BRIEF.md
# Serial Character Transmitter with Flow Control

This block turns parallel characters into an asynchronous serial stream. A character written by the host waits in a single holding stage. When the shifter is idle it moves into the shifter, which sends a low start bit, five to eight data bits with the least significant first, an optional parity bit and a stop period at mark level. Every bit is timed by a free-running enable pulse at sixteen times the bit rate.

Around that datapath sit the controls a host needs to pace a link. Commands enable, disable and reset the transmitter. A clear-to-send input holds back new characters. Commands start and end a line break. A request-to-send output can be set and cleared by command, and in automatic mode it drops by itself once the transmitter is disabled and has nothing left to send. A disable is gentle: the character on the line finishes and the waiting one is kept. A reset command is abrupt. A break waits for pending characters, except when clear-to-send is blocking them.

Top module: `sertx_top`

## Requirements
- R1: A frame is one low start bit, then the data bits least significant first, then the parity bit if enabled, then the stop period at high level. Each bit lasts 16 `tick16` pulses. `cfg_len` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Written bits above the selected length are not sent.
- R2: `cfg_stop` value 0 gives a stop period of 16 pulses, 1 gives 24 and 2 or 3 gives 32. `tx_empty` rises in the cycle after the last pulse of the stop period.
- R3: `cfg_parity` value 0 (or 6, 7) sends no parity bit. Value 1 makes the count of ones over data and parity even, 2 makes it odd, 3 sends a constant 0, 4 sends a constant 1 and 5 sends the `wr_addr_bit` value that was written with the character.
- R4: `tx_ready` is high when the transmitter is enabled and the holding stage is free. It falls in the cycle after an accepted write and rises again in the cycle after the character moves into an idle shifter.
- R5: `tx_empty` is high when both the holding stage and the shifter are empty. It falls in the cycle after an accepted write. While it is high and no break is active, `txd` is high.
- R6: A write is ignored while the transmitter is disabled or while the holding stage is full.
- R7: Command 2 (disable) lets the frame in progress finish. A held character is kept and is not sent until command 1 (enable).
- R8: Command 3 (reset) returns `txd` to high in the next cycle, discards the held character and leaves the transmitter disabled until command 1.
- R9: When `cfg_cts_en` is 1, a character starts only while `cts_n` is low. A frame already in progress completes when `cts_n` rises, and the line then stays high until `cts_n` falls.
- R10: Command 4 (break on) drives `txd` low without a gap. It starts once the holding stage and the shifter are empty, or as soon as the shifter is idle if clear-to-send is blocking the held character. Once started, the break ignores `cts_n`.
- R11: A break ends only on command 5 (break off), 2 or 3. No character is sent during a break, and a character written during a break is sent after command 5.
- R12: Command 6 drives `rts_n` low and command 7 drives it high. When `cfg_auto_rts` is 1, `rts_n` goes high in the cycle after the transmitter is disabled and empty. When `cfg_auto_rts` is 0, `rts_n` keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Enable pulse at sixteen times the bit rate |
| cfg_len | input | 2 | Data length code, 5 + value bits |
| cfg_parity | input | 3 | Parity mode code |
| cfg_stop | input | 2 | Stop period code |
| cfg_cts_en | input | 1 | Honour clear-to-send when 1 |
| cfg_auto_rts | input | 1 | Automatic request-to-send negation when 1 |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command: 1 enable, 2 disable, 3 reset, 4 break on, 5 break off, 6 rts on, 7 rts off |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Character to send |
| wr_addr_bit | input | 1 | Address/data flag, used as the parity bit in mode 5 |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial line, high at mark |
| tx_ready | output | 1 | Holding stage can take a character |
| tx_empty | output | 1 | Holding stage and shifter both empty |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
Flag and command results are due in the cycle after the clock edge that takes the stimulus. A character moves into an idle shifter one edge after the write. The serial line is a register path, so the start bit appears on the edge that loads the shifter. Stimulus is driven on falling clock edges and each flag is sampled on the next falling edge, one edge after the action. Serial data is decoded by counting `tick16` pulses from the first low sample and sampling mid-bit, 8 pulses and then every 16 pulses later. The stop period is checked by counting pulses from the start bit to the first cycle in which `tx_empty` is high.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int CHAR_MAX = 8;

    typedef enum logic [2:0] {
        CMD_NOP     = 3'd0,
        CMD_ENABLE  = 3'd1,
        CMD_DISABLE = 3'd2,
        CMD_RESET   = 3'd3,
        CMD_BRK_ON  = 3'd4,
        CMD_BRK_OFF = 3'd5,
        CMD_RTS_ON  = 3'd6,
        CMD_RTS_OFF = 3'd7
    } txcmd_e;

    localparam logic [2:0] PAR_NONE = 3'd0;
    localparam logic [2:0] PAR_EVEN = 3'd1;
    localparam logic [2:0] PAR_ODD  = 3'd2;
    localparam logic [2:0] PAR_LOW  = 3'd3;
    localparam logic [2:0] PAR_HIGH = 3'd4;
    localparam logic [2:0] PAR_ADDR = 3'd5;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_START,
        FS_DATA,
        FS_PAR,
        FS_STOP
    } fstate_e;

    typedef struct packed {
        logic [CHAR_MAX-1:0] data;
        logic                adbit;
    } hold_t;

    typedef struct packed {
        logic [1:0] len_code;
        logic [2:0] par;
        logic [1:0] stop;
    } fmt_t;

    function automatic logic [3:0] char_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic has_parity(input logic [2:0] p);
        return (p >= PAR_EVEN) && (p <= PAR_ADDR);
    endfunction

    function automatic logic calc_parity(input logic [CHAR_MAX-1:0] d,
                                         input logic [1:0] code,
                                         input logic [2:0] p,
                                         input logic ad);
        logic [CHAR_MAX-1:0] m;
        logic x;
        for (int i = 0; i < CHAR_MAX; i++) begin
            m[i] = d[i] & (i < int'(code) + 5);
        end
        x = ^m;
        case (p)
            PAR_EVEN: return x;
            PAR_ODD:  return ~x;
            PAR_LOW:  return 1'b0;
            PAR_HIGH: return 1'b1;
            PAR_ADDR: return ad;
            default:  return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_req,
    input  hold_t wr_char,
    input  logic  enabled,
    input  logic  take,
    input  logic  flush,
    output logic  valid,
    output hold_t q
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            valid <= 1'b0;
            q     <= '0;
        end else if (take) begin
            valid <= 1'b0;
        end else if (wr_req && enabled && !valid) begin
            valid <= 1'b1;
            q     <= wr_char;
        end
    end

    // R6: a full holding stage keeps its character against further writes
    a_r6_full_kept: assert property (@(posedge clk) disable iff (rst)
        (valid && !take && !flush) |=> (valid && $stable(q)));

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  abort,
    input  logic  load,
    input  hold_t ch,
    input  fmt_t  fmt,
    output logic  line,
    output logic  idle
);

    localparam int CW = $clog2(2 * TICKS_PER_BIT + 1);
    localparam logic [CW-1:0] LEN_ONE  = CW'(TICKS_PER_BIT);
    localparam logic [CW-1:0] LEN_HALF = CW'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
    localparam logic [CW-1:0] LEN_TWO  = CW'(2 * TICKS_PER_BIT);

    fstate_e             st;
    logic [CHAR_MAX-1:0] sh;
    logic [3:0]          left;
    logic                pbit;
    logic                use_par;
    logic [CW-1:0]       cnt;
    logic [CW-1:0]       stop_len;
    logic [CW-1:0]       limit;
    logic                bit_end;

    always_comb begin
        limit   = (st == FS_STOP) ? stop_len : LEN_ONE;
        bit_end = tick && (cnt == limit - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st      <= FS_IDLE;
            cnt     <= '0;
            sh      <= '0;
            left    <= '0;
            pbit    <= 1'b1;
            use_par <= 1'b0;
            stop_len <= LEN_ONE;
        end else if (st == FS_IDLE) begin
            if (load) begin
                st      <= FS_START;
                cnt     <= '0;
                sh      <= ch.data;
                left    <= char_bits(fmt.len_code);
                pbit    <= calc_parity(ch.data, fmt.len_code, fmt.par, ch.adbit);
                use_par <= has_parity(fmt.par);
                case (fmt.stop)
                    2'd0:    stop_len <= LEN_ONE;
                    2'd1:    stop_len <= LEN_HALF;
                    default: stop_len <= LEN_TWO;
                endcase
            end
        end else if (tick) begin
            if (bit_end) begin
                cnt <= '0;
                case (st)
                    FS_START: st <= FS_DATA;
                    FS_DATA: begin
                        sh   <= sh >> 1;
                        left <= left - 4'd1;
                        if (left == 4'd1) begin
                            st <= use_par ? FS_PAR : FS_STOP;
                        end
                    end
                    FS_PAR:  st <= FS_STOP;
                    default: st <= FS_IDLE;
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        case (st)
            FS_START: line = 1'b0;
            FS_DATA:  line = sh[0];
            FS_PAR:   line = pbit;
            default:  line = 1'b1;
        endcase
        idle = (st == FS_IDLE);
    end

    // R1: data state always has bits left to send, never more than a full character
    a_r1_data_left: assert property (@(posedge clk) disable iff (rst)
        (st == FS_DATA) |-> (left != 4'd0 && left <= 4'(CHAR_MAX)));

    // R2: the stop period never runs past its programmed length
    a_r2_stop_window: assert property (@(posedge clk) disable iff (rst)
        (st == FS_STOP) |-> (cnt < stop_len));

endmodule

// File: rtl/sertx_ctl.sv
module sertx_ctl
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [2:0] cmd,
    input  logic       auto_rts,
    input  logic       frame_idle,
    input  logic       hold_valid,
    input  logic       cts_block,
    output logic       enabled,
    output logic       brk_act,
    output logic       flush,
    output logic       rts_n
);

    logic   brk_pend;
    logic   rts_on;
    txcmd_e c;
    logic   ends_break;

    always_comb begin
        c          = txcmd_e'(cmd);
        flush      = cmd_valid && (c == CMD_RESET);
        ends_break = cmd_valid && (c == CMD_DISABLE || c == CMD_RESET || c == CMD_BRK_OFF);
        rts_n      = !rts_on;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enabled  <= 1'b0;
            brk_pend <= 1'b0;
            brk_act  <= 1'b0;
            rts_on   <= 1'b0;
        end else begin
            if (brk_pend && !brk_act && frame_idle && (!hold_valid || cts_block)) begin
                brk_act  <= 1'b1;
                brk_pend <= 1'b0;
            end
            if (auto_rts && !enabled && frame_idle && !hold_valid) begin
                rts_on <= 1'b0;
            end
            if (cmd_valid) begin
                case (c)
                    CMD_ENABLE: enabled <= 1'b1;
                    CMD_DISABLE, CMD_RESET: begin
                        enabled  <= 1'b0;
                        brk_pend <= 1'b0;
                        brk_act  <= 1'b0;
                    end
                    CMD_BRK_ON:  if (enabled) brk_pend <= 1'b1;
                    CMD_BRK_OFF: begin
                        brk_pend <= 1'b0;
                        brk_act  <= 1'b0;
                    end
                    CMD_RTS_ON:  rts_on <= 1'b1;
                    CMD_RTS_OFF: rts_on <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    // R11: an active break persists until one of its ending commands
    a_r11_break_held: assert property (@(posedge clk) disable iff (rst)
        (brk_act && !ends_break) |=> brk_act);

    // R12: automatic mode releases request-to-send once disabled and empty
    a_r12_auto_rts: assert property (@(posedge clk) disable iff (rst)
        (auto_rts && !enabled && frame_idle && !hold_valid &&
         !(cmd_valid && c == CMD_RTS_ON)) |=> rts_n);

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic [1:0] cfg_len,
    input  logic [2:0] cfg_parity,
    input  logic [1:0] cfg_stop,
    input  logic       cfg_cts_en,
    input  logic       cfg_auto_rts,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_addr_bit,
    input  logic       cts_n,
    output logic       txd,
    output logic       tx_ready,
    output logic       tx_empty,
    output logic       rts_n
);

    logic  enabled;
    logic  brk_act;
    logic  flush;
    logic  hold_valid;
    hold_t hold_q;
    hold_t wr_char;
    fmt_t  fmt;
    logic  frame_idle;
    logic  frame_line;
    logic  cts_blocked;
    logic  load;

    always_comb begin
        wr_char     = '{data: wr_data, adbit: wr_addr_bit};
        fmt         = '{len_code: cfg_len, par: cfg_parity, stop: cfg_stop};
        cts_blocked = cfg_cts_en && cts_n;
        load        = hold_valid && frame_idle && enabled && !cts_blocked && !brk_act && !flush;
    end

    sertx_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd_code),
        .auto_rts   (cfg_auto_rts),
        .frame_idle (frame_idle),
        .hold_valid (hold_valid),
        .cts_block  (cts_blocked),
        .enabled    (enabled),
        .brk_act    (brk_act),
        .flush      (flush),
        .rts_n      (rts_n)
    );

    sertx_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_en),
        .wr_char (wr_char),
        .enabled (enabled),
        .take    (load),
        .flush   (flush),
        .valid   (hold_valid),
        .q       (hold_q)
    );

    sertx_frame #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_frame (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick16),
        .abort (flush),
        .load  (load),
        .ch    (hold_q),
        .fmt   (fmt),
        .line  (frame_line),
        .idle  (frame_idle)
    );

    always_comb begin
        txd      = brk_act ? 1'b0 : frame_line;
        tx_ready = enabled && !hold_valid;
        tx_empty = frame_idle && !hold_valid;
    end

    // R4: an accepted write takes the ready flag down on the next edge
    a_r4_ready_drop: assert property (@(posedge clk) disable iff (rst)
        (wr_en && tx_ready && !flush) |=> !tx_ready);

    // R5: empty with no break means the line sits at mark
    a_r5_empty_mark: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !brk_act) |-> txd);

    // R8: reset command returns line to mark and leaves nothing queued
    a_r8_reset_mark: assert property (@(posedge clk) disable iff (rst)
        flush |=> (txd && tx_empty && !tx_ready));

    // R9: a frame only begins when clear-to-send allowed it
    a_r9_cts_start: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_idle) |-> $past(!cts_blocked));

    // R10: no frame is running while the break holds the line
    a_r10_break_idle: assert property (@(posedge clk) disable iff (rst)
        brk_act |-> frame_idle);

endmodule

// File: tb/test_sertx_top.sv
module test_sertx_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic [1:0] div = 2'd0;
    logic [1:0] cfg_len = 2'd3;
    logic [2:0] cfg_parity = 3'd0;
    logic [1:0] cfg_stop = 2'd0;
    logic       cfg_cts_en = 1'b0;
    logic       cfg_auto_rts = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       wr_addr_bit = 1'b0;
    logic       cts_n = 1'b0;
    logic       txd, tx_ready, tx_empty, rts_n;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        div    <= div + 2'd1;
        tick16 <= (div == 2'd3);
    end

    sertx_top i_sertx_top (
        .clk(clk), .rst(rst), .tick16(tick16),
        .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_stop(cfg_stop),
        .cfg_cts_en(cfg_cts_en), .cfg_auto_rts(cfg_auto_rts),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .wr_en(wr_en), .wr_data(wr_data), .wr_addr_bit(wr_addr_bit),
        .cts_n(cts_n), .txd(txd), .tx_ready(tx_ready),
        .tx_empty(tx_empty), .rts_n(rts_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic write(input logic [7:0] d, input logic ad);
        @(negedge clk);
        wr_en       = 1'b1;
        wr_data     = d;
        wr_addr_bit = ad;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick_wait(input int n);
        int c = 0;
        while (c < n) begin
            if (tick16) c++;
            @(negedge clk);
        end
    endtask

    task automatic quiet(input string req, input string what, input int n, input logic val);
        int c = 0;
        int bad = 0;
        while (c < n) begin
            if (txd !== val) bad++;
            if (tick16) c++;
            @(negedge clk);
        end
        chk(req, what, bad, 0);
    endtask

    task automatic wait_fall(input string req);
        int c = 0;
        while (txd === 1'b1 && c < 4000) begin
            @(negedge clk);
            c++;
        end
        chk(req, "start edge seen", txd, 0);
    endtask

    task automatic wait_empty(input string req);
        int c = 0;
        while (tx_empty !== 1'b1 && c < 4000) begin
            @(negedge clk);
            c++;
        end
        chk(req, "empty reached", tx_empty, 1);
    endtask

    function automatic logic exp_par(input logic [7:0] d, input int nb,
                                     input logic [2:0] mode, input logic ad);
        int ones = 0;
        for (int i = 0; i < nb; i++) ones += int'(d[i]);
        case (mode)
            3'd1: return logic'(ones % 2);
            3'd2: return !logic'(ones % 2);
            3'd3: return 1'b0;
            3'd4: return 1'b1;
            default: return ad;
        endcase
    endfunction

    // decodes a frame whose start edge was just observed
    task automatic decode_rest(input string req, input logic [7:0] d, input logic ad);
        int nb = int'(cfg_len) + 5;
        logic par_on = (cfg_parity >= 3'd1 && cfg_parity <= 3'd5);
        logic [7:0] got = 8'd0;
        logic [7:0] mask = 8'((1 << nb) - 1);
        logic s;
        tick_wait(8);
        chk(req, "start bit", txd, 0);
        for (int i = 0; i < nb; i++) begin
            tick_wait(16);
            got[i] = txd;
        end
        chk(req, "data", got, d & mask);
        if (par_on) begin
            tick_wait(16);
            chk(req, "parity", txd, exp_par(d, nb, cfg_parity, ad));
        end
        tick_wait(16);
        s = txd;
        chk(req, "stop bit", s, 1);
    endtask

    task automatic rx_char(input string req, input logic [7:0] d, input logic ad);
        wait_fall(req);
        decode_rest(req, d, ad);
    endtask

    task automatic t_reset_state;
        chk("R5", "reset txd", txd, 1);
        chk("R4", "reset ready", tx_ready, 0);
        chk("R5", "reset empty", tx_empty, 1);
        chk("R12", "reset rts_n", rts_n, 1);
    endtask

    task automatic t_formats;
        do_cmd(3'd1);
        chk("R4", "ready after enable", tx_ready, 1);
        cfg_len = 2'd3; cfg_parity = 3'd0; cfg_stop = 2'd0;
        write(8'hA5, 1'b0);
        chk("R4", "ready falls after write", tx_ready, 0);
        chk("R5", "empty falls after write", tx_empty, 0);
        @(negedge clk);
        chk("R4", "ready back after move", tx_ready, 1);
        chk("R1", "start on load", txd, 0);
        decode_rest("R1", 8'hA5, 1'b0);
        wait_empty("R5");
        cfg_len = 2'd2; cfg_parity = 3'd1;
        write(8'h5B, 1'b0); rx_char("R3", 8'h5B, 1'b0); wait_empty("R3");
        cfg_len = 2'd1; cfg_parity = 3'd2;
        write(8'h2D, 1'b0); rx_char("R3", 8'h2D, 1'b0); wait_empty("R3");
        cfg_len = 2'd0; cfg_parity = 3'd4;
        write(8'h33, 1'b0); rx_char("R1", 8'h33, 1'b0); wait_empty("R1");
        cfg_len = 2'd3; cfg_parity = 3'd3;
        write(8'h96, 1'b0); rx_char("R3", 8'h96, 1'b0); wait_empty("R3");
        cfg_parity = 3'd5;
        write(8'h41, 1'b1); rx_char("R3", 8'h41, 1'b1); wait_empty("R3");
        write(8'h42, 1'b0); rx_char("R3", 8'h42, 1'b0); wait_empty("R3");
        cfg_parity = 3'd0;
        // full holding stage: third write is dropped
        write(8'h11, 1'b0);
        write(8'h22, 1'b0);
        write(8'h33, 1'b0);
        rx_char("R6", 8'h11, 1'b0);
        rx_char("R6", 8'h22, 1'b0);
        wait_empty("R6");
        quiet("R6", "no third frame", 40, 1'b1);
    endtask

    task automatic t_stop_len;
        int exp_len [3] = '{16, 24, 32};
        for (int k = 0; k < 3; k++) begin
            int c = 0;
            cfg_stop = 2'(k);
            write(8'hC3, 1'b0);
            wait_fall("R2");
            while (tx_empty !== 1'b1 && c < 400) begin
                if (tick16) c++;
                @(negedge clk);
            end
            chk("R2", "frame length in ticks", c, 144 + exp_len[k]);
        end
        cfg_stop = 2'd0;
    endtask

    task automatic t_disable;
        write(8'h5A, 1'b0);
        @(negedge clk);
        write(8'h6B, 1'b0);
        do_cmd(3'd2);
        chk("R7", "ready low when disabled", tx_ready, 0);
        decode_rest("R7", 8'h5A, 1'b0);
        tick_wait(16);
        quiet("R7", "held char not sent", 40, 1'b1);
        chk("R7", "held char kept", tx_empty, 0);
        write(8'h77, 1'b0);
        do_cmd(3'd1);
        rx_char("R7", 8'h6B, 1'b0);
        wait_empty("R6");
        quiet("R6", "disabled write dropped", 40, 1'b1);
    endtask

    task automatic t_reset_cmd;
        write(8'h81, 1'b0);
        @(negedge clk);
        write(8'h82, 1'b0);
        tick_wait(20);
        do_cmd(3'd3);
        chk("R8", "line mark at once", txd, 1);
        chk("R8", "held discarded", tx_empty, 1);
        chk("R8", "ready low after reset", tx_ready, 0);
        write(8'h83, 1'b0);
        chk("R8", "write ignored while disabled", tx_empty, 1);
        quiet("R8", "nothing sent after reset", 40, 1'b1);
        do_cmd(3'd1);
        chk("R8", "ready after re-enable", tx_ready, 1);
        quiet("R8", "discarded stays discarded", 40, 1'b1);
    endtask

    task automatic t_cts;
        cfg_cts_en = 1'b1;
        cts_n = 1'b1;
        write(8'h3E, 1'b0);
        quiet("R9", "blocked by cts", 30, 1'b1);
        chk("R9", "char waiting", tx_empty, 0);
        cts_n = 1'b0;
        wait_fall("R9");
        cts_n = 1'b1;
        decode_rest("R9", 8'h3E, 1'b0);
        write(8'h4F, 1'b0);
        tick_wait(16);
        quiet("R9", "mark while cts high", 40, 1'b1);
        chk("R9", "next char held", tx_empty, 0);
        cts_n = 1'b0;
        rx_char("R9", 8'h4F, 1'b0);
        wait_empty("R9");
        cfg_cts_en = 1'b0;
    endtask

    task automatic t_break;
        write(8'hD1, 1'b0);
        @(negedge clk);
        write(8'hD2, 1'b0);
        do_cmd(3'd4);
        rx_char("R10", 8'hD1, 1'b0);
        rx_char("R10", 8'hD2, 1'b0);
        tick_wait(20);
        quiet("R10", "break holds line low", 40, 1'b0);
        cfg_cts_en = 1'b1;
        cts_n = 1'b1;
        quiet("R10", "break ignores cts", 20, 1'b0);
        cts_n = 1'b0;
        write(8'hD3, 1'b0);
        quiet("R11", "no char during break", 40, 1'b0);
        do_cmd(3'd5);
        chk("R11", "break off returns mark", txd, 1);
        rx_char("R11", 8'hD3, 1'b0);
        wait_empty("R11");
        // break while clear-to-send blocks the held char starts at once
        cts_n = 1'b1;
        write(8'hD4, 1'b0);
        do_cmd(3'd4);
        @(negedge clk);
        chk("R10", "immediate break under cts", txd, 0);
        chk("R10", "char still held", tx_empty, 0);
        do_cmd(3'd2);
        chk("R11", "disable ends break", txd, 1);
        do_cmd(3'd3);
        cts_n = 1'b0;
        cfg_cts_en = 1'b0;
        do_cmd(3'd1);
    endtask

    task automatic t_rts;
        do_cmd(3'd6);
        chk("R12", "rts on command", rts_n, 0);
        do_cmd(3'd7);
        chk("R12", "rts off command", rts_n, 1);
        cfg_auto_rts = 1'b1;
        do_cmd(3'd6);
        tick_wait(4);
        chk("R12", "auto keeps rts while enabled", rts_n, 0);
        write(8'hE7, 1'b0);
        do_cmd(3'd2);
        wait_fall("R12");
        chk("R12", "rts held during frame", rts_n, 0);
        decode_rest("R12", 8'hE7, 1'b0);
        wait_empty("R12");
        chk("R12", "rts still low when empty appears", rts_n, 0);
        @(negedge clk);
        chk("R12", "auto negation", rts_n, 1);
        cfg_auto_rts = 1'b0;
        do_cmd(3'd6);
        tick_wait(4);
        chk("R12", "manual mode keeps rts", rts_n, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_formats();
        t_stop_len();
        t_disable();
        t_reset_cmd();
        t_cts();
        t_break();
        t_rts();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule